// File: doc/BRIEF.md
# Slotted-Ring Subframe Access Controller

This per-node controller decides, slot by slot, whether the node may place a packet into the passing slot of a slotted ring, and how the slot header leaves the node. Every frame opens with a guaranteed-traffic (synchronous) phase. It is followed by a best-effort (asynchronous) phase that fills the rest of the frame. The controller watches a frame-start pulse, the header of each incoming slot (busy bit, class bit and claim address) and two queue-pending flags. For each slot it returns a grant tagged with the traffic class, together with the rewritten header, one clock later.

The synchronous phase holds a per-frame allowance. Every frame-start pulse reloads it. While the node still has guaranteed traffic and allowance left, it stamps its own address and class 0 into each passing header, so that nodes further along can tell it is still busy. Once the node has nothing more to send in this phase, it stops stamping. When its own class-0 stamp comes back around the ring, every node has finished, and the node moves into the best-effort phase. In that phase it stamps its address with class 1. The best-effort allowance is not tied to frames. It is reloaded only when the node, after running out, sees its own class-1 stamp return. That event closes the best-effort cycle, which may last for many frames.

The controller has five named states. IDLE holds from reset until the first frame start. SYNC_CLAIM is synchronous-active. SYNC_WAIT is synchronous-inactive, waiting for the node's own class-0 stamp. ASYNC_CLAIM is asynchronous-active. ASYNC_WAIT is asynchronous-inactive, waiting for the node's own class-1 stamp. The transitions are:
- frame start: any state goes to SYNC_CLAIM.
- sync exhausted: SYNC_CLAIM goes to SYNC_WAIT when the guaranteed queue is empty or the allowance is zero.
- sync closed: SYNC_WAIT goes to ASYNC_CLAIM when the node's own address arrives with class 0.
- async exhausted: ASYNC_CLAIM goes to ASYNC_WAIT.
- cycle reset: ASYNC_WAIT goes to ASYNC_CLAIM when the node's own address arrives with class 1.

The exhausted and closed transitions are evaluated on the slot that triggers them, and that slot is handled under the new state.

Top module: `subframe_access_ctrl`

## Requirements
- R1: After reset every output is 0. Until the first frame-start pulse, each slot leaves exactly as it arrived and is never granted.
- R2: A slot presented with `slot_vld` high appears on the outputs one clock later with `out_vld` high. A cycle without `slot_vld` gives `out_vld` low and every other output 0.
- R3: In SYNC_CLAIM each slot leaves with `out_addr` equal to `my_addr` and `out_dtype` = 0. If the slot arrived empty (busy = 0), it is granted with `tx_async` = 0 and leaves with `out_busy` = 1.
- R4: At most `quota_sync` synchronous grants are given per frame. After the last one the node stops stamping, and a zero allowance gives no synchronous grant at all.
- R5: An empty guaranteed queue makes the node synchronous-inactive at once, with no stamping.
- R6: In SYNC_WAIT or ASYNC_WAIT, an empty slot is granted as best-effort (`tx_async` = 1) when the best-effort queue is pending and allowance remains. That slot's address and class bits pass unchanged.
- R7: In SYNC_WAIT, a slot carrying `my_addr` with class 0 ends the synchronous phase. That slot and the following ones are stamped with `my_addr` and class 1, and empty ones are granted as best-effort.
- R8: The best-effort allowance (`quota_async`, first loaded at the first frame start) is shared across frames. A frame start does not reload it.
- R9: In ASYNC_WAIT, a slot carrying `my_addr` with class 1 reloads `quota_async`. That slot passes unchanged and ungranted, and the node claims again from the next slot.
- R10: A frame-start pulse in any phase returns the node to SYNC_CLAIM with `quota_sync` reloaded. A slot in the same cycle as the pulse is handled under the new frame.
- R11: A slot arriving busy is never granted and leaves busy.
- R12: In SYNC_WAIT, the node's own address with class 1 does not end the synchronous phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_addr | input | AW | This node's ring address |
| quota_sync | input | QW | Synchronous slots allowed per frame |
| quota_async | input | QW | Best-effort slots allowed per best-effort cycle |
| frame_start | input | 1 | Frame boundary pulse |
| slot_vld | input | 1 | A slot header is present this cycle |
| hdr_busy | input | 1 | Incoming busy bit |
| hdr_dtype | input | 1 | Incoming class bit (0 synchronous, 1 best-effort) |
| hdr_addr | input | AW | Incoming claim address |
| sync_pend | input | 1 | Guaranteed queue not empty |
| async_pend | input | 1 | Best-effort queue not empty |
| out_vld | output | 1 | Rewritten slot present |
| out_busy | output | 1 | Outgoing busy bit |
| out_dtype | output | 1 | Outgoing class bit |
| out_addr | output | AW | Outgoing claim address |
| tx_grant | output | 1 | Node may fill this slot |
| tx_async | output | 1 | Grant is best-effort (1) or synchronous (0) |

## Verification
A wrong phase state shows up in the first slot handled afterwards. A node stuck in SYNC_CLAIM keeps stamping class 0 where class 1 or an untouched header is due. A node that leaves SYNC_WAIT too early stamps class 1 on the following slot. A miscounted allowance shows up as one grant too many or too few, at the slot where the count should reach zero. A best-effort counter wrongly reloaded at a frame start is visible as a best-effort grant that should not occur. The directed scenarios therefore check every slot of each phase change, one slot after it enters.

// File: rtl/sfac_pkg.sv
package sfac_pkg;

    typedef enum logic [2:0] {
        PH_IDLE        = 3'd0,
        PH_SYNC_CLAIM  = 3'd1,
        PH_SYNC_WAIT   = 3'd2,
        PH_ASYNC_CLAIM = 3'd3,
        PH_ASYNC_WAIT  = 3'd4
    } phase_e;

    localparam logic CLASS_SYNC  = 1'b0;
    localparam logic CLASS_ASYNC = 1'b1;

endpackage

// File: rtl/sfac_quota_ctr.sv
module sfac_quota_ctr #(
    parameter int QW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          dec,
    output logic [QW-1:0] count,
    output logic          nonzero
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val - QW'(dec);
        end else if (dec) begin
            count <= count - QW'(1);
        end
    end

    assign nonzero = (count != '0);

    // R4 / R8: a grant is never charged against an exhausted allowance
    p_quota_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (load ? (load_val != '0) : (count != '0)));

endmodule

// File: rtl/sfac_hdr_rewrite.sv
module sfac_hdr_rewrite #(
    parameter int AW = 6
) (
    input  logic          in_busy,
    input  logic          in_dtype,
    input  logic [AW-1:0] in_addr,
    input  logic [AW-1:0] my_addr,
    input  logic          claim,
    input  logic          claim_dtype,
    input  logic          send,
    output logic          new_busy,
    output logic          new_dtype,
    output logic [AW-1:0] new_addr
);

    always_comb begin
        new_busy  = in_busy | send;
        new_dtype = claim ? claim_dtype : in_dtype;
        new_addr  = claim ? my_addr : in_addr;
    end

endmodule

// File: rtl/sfac_phase_fsm.sv
module sfac_phase_fsm
    import sfac_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          slot_vld,
    input  logic          hdr_busy,
    input  logic          hdr_dtype,
    input  logic [AW-1:0] hdr_addr,
    input  logic [AW-1:0] my_addr,
    input  logic          sync_pend,
    input  logic          async_pend,
    input  logic          qs_nz,
    input  logic          qa_nz,
    input  logic          sync_cnt_nz,
    input  logic          async_cnt_nz,
    output logic          claim,
    output logic          claim_dtype,
    output logic          send,
    output logic          send_async,
    output logic          sync_load,
    output logic          sync_dec,
    output logic          async_load,
    output logic          async_dec
);

    phase_e st, nxt, entry, act;
    logic   own_hit, sync_ok, async_ok, first_frame, cyc_reset;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= PH_IDLE;
        else        st <= nxt;
    end

    // behaviour of this cycle: the phase after any slot-triggered change
    always_comb begin
        first_frame = frame_start && (st == PH_IDLE);
        entry       = frame_start ? PH_SYNC_CLAIM : st;
        own_hit     = (hdr_addr == my_addr);
        sync_ok     = sync_pend && (frame_start ? qs_nz : sync_cnt_nz);
        async_ok    = async_pend && (first_frame ? qa_nz : async_cnt_nz);
        act         = entry;
        cyc_reset   = 1'b0;
        if (slot_vld) begin
            if (act == PH_SYNC_CLAIM && !sync_ok)                act = PH_SYNC_WAIT;
            if (act == PH_SYNC_WAIT && own_hit && !hdr_dtype)    act = PH_ASYNC_CLAIM;
            if (act == PH_ASYNC_CLAIM && !async_ok)              act = PH_ASYNC_WAIT;
            if (act == PH_ASYNC_WAIT && own_hit && hdr_dtype)    cyc_reset = 1'b1;
        end
        nxt = cyc_reset ? PH_ASYNC_CLAIM : act;
    end

    always_comb begin
        claim       = 1'b0;
        claim_dtype = CLASS_SYNC;
        send        = 1'b0;
        send_async  = 1'b0;
        sync_dec    = 1'b0;
        async_dec   = 1'b0;
        sync_load   = frame_start;
        async_load  = first_frame || cyc_reset;
        if (slot_vld && !cyc_reset) begin
            unique case (act)
                PH_IDLE: begin
                end
                PH_SYNC_CLAIM: begin
                    claim       = 1'b1;
                    claim_dtype = CLASS_SYNC;
                    if (!hdr_busy) begin
                        send     = 1'b1;
                        sync_dec = 1'b1;
                    end
                end
                PH_SYNC_WAIT, PH_ASYNC_WAIT: begin
                    if (!hdr_busy && async_ok) begin
                        send       = 1'b1;
                        send_async = 1'b1;
                        async_dec  = 1'b1;
                    end
                end
                PH_ASYNC_CLAIM: begin
                    claim       = 1'b1;
                    claim_dtype = CLASS_ASYNC;
                    if (!hdr_busy) begin
                        send       = 1'b1;
                        send_async = 1'b1;
                        async_dec  = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // R11: grants only go to empty, present slots
    p_send_empty_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        send |-> (slot_vld && !hdr_busy));

    // R10: a bare frame-start pulse lands the phase register in the synchronous phase
    p_frame_reenter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !slot_vld) |=> (st == PH_SYNC_CLAIM));

    // R6: a grant is charged to exactly one allowance
    p_one_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sync_dec, async_dec}));

    // R1: before the first frame the node never touches a slot
    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_IDLE && !frame_start) |-> (!claim && !send));

endmodule

// File: rtl/subframe_access_ctrl.sv
module subframe_access_ctrl
    import sfac_pkg::*;
#(
    parameter int AW = 6,
    parameter int QW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] my_addr,
    input  logic [QW-1:0] quota_sync,
    input  logic [QW-1:0] quota_async,
    input  logic          frame_start,
    input  logic          slot_vld,
    input  logic          hdr_busy,
    input  logic          hdr_dtype,
    input  logic [AW-1:0] hdr_addr,
    input  logic          sync_pend,
    input  logic          async_pend,
    output logic          out_vld,
    output logic          out_busy,
    output logic          out_dtype,
    output logic [AW-1:0] out_addr,
    output logic          tx_grant,
    output logic          tx_async
);

    logic          claim, claim_dtype, send, send_async;
    logic          sync_load, sync_dec, async_load, async_dec;
    logic [QW-1:0] sync_cnt, async_cnt;
    logic          sync_cnt_nz, async_cnt_nz;
    logic          nb, nd;
    logic [AW-1:0] na;

    sfac_phase_fsm #(.AW(AW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .slot_vld     (slot_vld),
        .hdr_busy     (hdr_busy),
        .hdr_dtype    (hdr_dtype),
        .hdr_addr     (hdr_addr),
        .my_addr      (my_addr),
        .sync_pend    (sync_pend),
        .async_pend   (async_pend),
        .qs_nz        (quota_sync != '0),
        .qa_nz        (quota_async != '0),
        .sync_cnt_nz  (sync_cnt_nz),
        .async_cnt_nz (async_cnt_nz),
        .claim        (claim),
        .claim_dtype  (claim_dtype),
        .send         (send),
        .send_async   (send_async),
        .sync_load    (sync_load),
        .sync_dec     (sync_dec),
        .async_load   (async_load),
        .async_dec    (async_dec)
    );

    sfac_quota_ctr #(.QW(QW)) u_sync_quota (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sync_load),
        .load_val (quota_sync),
        .dec      (sync_dec),
        .count    (sync_cnt),
        .nonzero  (sync_cnt_nz)
    );

    sfac_quota_ctr #(.QW(QW)) u_async_quota (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (async_load),
        .load_val (quota_async),
        .dec      (async_dec),
        .count    (async_cnt),
        .nonzero  (async_cnt_nz)
    );

    sfac_hdr_rewrite #(.AW(AW)) u_rewrite (
        .in_busy     (hdr_busy),
        .in_dtype    (hdr_dtype),
        .in_addr     (hdr_addr),
        .my_addr     (my_addr),
        .claim       (claim),
        .claim_dtype (claim_dtype),
        .send        (send),
        .new_busy    (nb),
        .new_dtype   (nd),
        .new_addr    (na)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_busy  <= 1'b0;
            out_dtype <= 1'b0;
            out_addr  <= '0;
            tx_grant  <= 1'b0;
            tx_async  <= 1'b0;
        end else begin
            out_vld   <= slot_vld;
            out_busy  <= slot_vld & nb;
            out_dtype <= slot_vld & nd;
            out_addr  <= slot_vld ? na : '0;
            tx_grant  <= send;
            tx_async  <= send & send_async;
        end
    end

    // R2: one-clock slot latency
    p_slot_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |=> out_vld);

    // R3: a granted slot leaves marked full
    p_grant_marks_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> (out_vld && out_busy));

    // R11: an occupied slot is never granted and stays occupied
    p_busy_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && hdr_busy) |=> (out_busy && !tx_grant));

    // R3: a synchronous grant always carries this node's class-0 stamp
    p_sync_grant_stamped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && !tx_async) |-> (out_addr == my_addr && out_dtype == CLASS_SYNC));

endmodule

// File: tb/subframe_access_ctrl_bench.sv
module subframe_access_ctrl_bench;

    localparam int AW = 6;
    localparam int QW = 4;
    localparam logic [AW-1:0] ME = 6'd5;
    localparam logic [AW-1:0] XX = 6'd9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [QW-1:0] quota_sync = 4'd2;
    logic [QW-1:0] quota_async = 4'd3;
    logic          frame_start = 1'b0;
    logic          slot_vld = 1'b0;
    logic          hdr_busy = 1'b0;
    logic          hdr_dtype = 1'b0;
    logic [AW-1:0] hdr_addr = '0;
    logic          sync_pend = 1'b1;
    logic          async_pend = 1'b1;
    logic          out_vld, out_busy, out_dtype, tx_grant, tx_async;
    logic [AW-1:0] out_addr;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    subframe_access_ctrl #(.AW(AW), .QW(QW)) u_subframe_access_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .my_addr     (ME),
        .quota_sync  (quota_sync),
        .quota_async (quota_async),
        .frame_start (frame_start),
        .slot_vld    (slot_vld),
        .hdr_busy    (hdr_busy),
        .hdr_dtype   (hdr_dtype),
        .hdr_addr    (hdr_addr),
        .sync_pend   (sync_pend),
        .async_pend  (async_pend),
        .out_vld     (out_vld),
        .out_busy    (out_busy),
        .out_dtype   (out_dtype),
        .out_addr    (out_addr),
        .tx_grant    (tx_grant),
        .tx_async    (tx_async)
    );

    task automatic expect_out(input string tag, input logic v, input logic g, input logic a,
                              input logic b, input logic d, input logic [AW-1:0] ad);
        logic [AW+4:0] got, exp;
        got = {out_vld, tx_grant, tx_async, out_busy, out_dtype, out_addr};
        exp = {v, g, a, b, d, ad};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got vld=%b grant=%b async=%b busy=%b dtype=%b addr=%0d, expected vld=%b grant=%b async=%b busy=%b dtype=%b addr=%0d",
                     tag, got[AW+4], got[AW+3], got[AW+2], got[AW+1], got[AW], got[AW-1:0],
                     exp[AW+4], exp[AW+3], exp[AW+2], exp[AW+1], exp[AW], exp[AW-1:0]);
        end
    endtask

    // one cycle of stimulus; outputs are sampled after the capturing edge
    task automatic step(input logic fs, input logic v, input logic b, input logic d,
                        input logic [AW-1:0] a);
        @(negedge clk);
        frame_start = fs;
        slot_vld    = v;
        hdr_busy    = b;
        hdr_dtype   = d;
        hdr_addr    = a;
        @(posedge clk);
        #2;
        frame_start = 1'b0;
        slot_vld    = 1'b0;
    endtask

    task automatic t_reset_idle;
        expect_out("R1 reset outputs", 0, 0, 0, 0, 0, '0);
        step(0, 1, 0, 1, XX);
        expect_out("R1 slot before first frame untouched", 1, 0, 0, 0, 1, XX);
        step(0, 0, 0, 0, '0);
        expect_out("R2 no slot gives no output", 0, 0, 0, 0, 0, '0);
    endtask

    task automatic t_full_frame;
        step(1, 0, 0, 0, '0);
        expect_out("R2 bare frame start", 0, 0, 0, 0, 0, '0);
        step(0, 1, 0, 0, XX);
        expect_out("R3 sync grant on empty slot", 1, 1, 0, 1, 0, ME);
        step(0, 1, 1, 1, XX);
        expect_out("R11 busy slot stamped not granted", 1, 0, 0, 1, 0, ME);
        step(0, 1, 0, 0, XX);
        expect_out("R3 second sync grant", 1, 1, 0, 1, 0, ME);
        step(0, 1, 0, 0, XX);
        expect_out("R4 quota used, R6 unstamped async grant", 1, 1, 1, 1, 0, XX);
        step(0, 1, 1, 1, ME);
        expect_out("R12 own addr class 1 passes", 1, 0, 0, 1, 1, ME);
        step(0, 1, 0, 0, XX);
        expect_out("R12 still sync-inactive", 1, 1, 1, 1, 0, XX);
        step(0, 1, 1, 0, ME);
        expect_out("R7 own class-0 stamp starts async phase", 1, 0, 0, 1, 1, ME);
        step(0, 1, 0, 0, XX);
        expect_out("R7 async claim and grant", 1, 1, 1, 1, 1, ME);
        step(0, 1, 0, 0, XX);
        expect_out("R8 async allowance exhausted", 1, 0, 0, 0, 0, XX);
    endtask

    task automatic t_persist_reset;
        step(1, 0, 0, 0, '0);
        step(0, 1, 0, 0, XX);
        expect_out("R10 new frame sync grant", 1, 1, 0, 1, 0, ME);
        step(0, 1, 0, 0, XX);
        expect_out("R4 second sync grant", 1, 1, 0, 1, 0, ME);
        step(0, 1, 0, 0, XX);
        expect_out("R8 frame start did not reload async", 1, 0, 0, 0, 0, XX);
        step(0, 1, 1, 0, ME);
        expect_out("R9 class-0 own stamp is no cycle reset", 1, 0, 0, 1, 0, ME);
        step(0, 1, 1, 1, ME);
        expect_out("R9 cycle reset slot unchanged", 1, 0, 0, 1, 1, ME);
        step(0, 1, 0, 0, XX);
        expect_out("R9 claims again after reload", 1, 1, 1, 1, 1, ME);
    endtask

    task automatic t_sync_empty;
        sync_pend = 1'b0;
        step(1, 0, 0, 0, '0);
        step(0, 1, 0, 0, XX);
        expect_out("R5 empty sync queue no stamp", 1, 1, 1, 1, 0, XX);
    endtask

    task automatic t_zero_quota;
        sync_pend   = 1'b1;
        async_pend  = 1'b0;
        quota_sync  = 4'd0;
        step(1, 0, 0, 0, '0);
        step(0, 1, 0, 0, XX);
        expect_out("R4 zero sync quota", 1, 0, 0, 0, 0, XX);
    endtask

    task automatic t_abort;
        quota_sync = 4'd2;
        async_pend = 1'b1;
        step(1, 1, 0, 0, XX);
        expect_out("R10 slot with frame start under new frame", 1, 1, 0, 1, 0, ME);
        step(0, 1, 0, 0, XX);
        expect_out("R4 sync grant", 1, 1, 0, 1, 0, ME);
        step(0, 1, 1, 0, ME);
        expect_out("R7 async phase entered", 1, 0, 0, 1, 1, ME);
        step(1, 1, 0, 1, XX);
        expect_out("R10 mid-async frame start returns to sync", 1, 1, 0, 1, 0, ME);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        t_reset_idle();
        t_full_frame();
        t_persist_reset();
        t_sync_empty();
        t_zero_quota();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule